// File: doc/BRIEF.md
# Size-Skewed Super-Block Tag Lookup

This block is the tag side of a compressed last-level cache. It answers read lookups without any stored size metadata. Sixteen ways are arranged as four way groups. Every tag entry describes one 64-byte data entry. That entry may hold one uncompressed block, or two, four or eight neighbouring blocks of a single aligned eight-block super-block, compressed to 32, 16 or 8 bytes each. An entry stores the super-block address and one valid state for each of the eight block positions.

The size of a requested block is not known at lookup time, so all ways are probed in the same cycle. Each way assumes the compression class implied by its own group number and two address bits. It then builds its own set index from a class-specific set of address bits and a way-specific hash, and checks that the stored super-block address matches and that the state of the requested block position is valid. The result is registered. It gives the hit flag, the way, the inferred compression class, and the byte offset and length of the block inside its data entry. A write port loads complete tag entries, as replacement logic outside the block would.

Top module: `sktl_lookup`

## Requirements
- R1: After reset every stored state is invalid, so every lookup misses until an entry is written; rsp_valid is low out of reset.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and low otherwise. The response reflects the array contents in the request cycle.
- R3: Way number w is read as w = g*4 + k, where g is the group in bits [3:2] and k is the slot in bits [1:0]. Way w assumes the class cf = A[10:9] XOR g, where class 0 means 64 bytes, 1 means 32, 2 means 16 and 3 means 8. A hit reports that way in rsp_way and that class in rsp_cf. At most one way hits.
- R4: Each way probes one set. A source vector is formed, least-significant-bit aligned and zero-extended to 40 bits: {A[47:11], A[8:6]} for class 0, {A[47:11], A[8:7]} for class 1, {A[47:11], A[8]} for class 2, and A[47:11] for class 3. The vector is folded to SET_W bits by XOR of consecutive SET_W-bit slices starting at bit 0. The fold is rotated left by k mod SET_W and XORed with g to give the set index. An entry at any other set is not found.
- R5: A hit requires the state bit selected by A[8:6] to be set. The other seven state bits have no effect on a lookup of that block.
- R6: A hit requires the stored 39-bit tag to equal A[47:9].
- R7: On a hit, rsp_len = 64 >> cf. rsp_offset is 0 for class 0, A[6]*32 for class 1, A[7:6]*16 for class 2 and A[8:6]*8 for class 3. On a miss, rsp_hit, rsp_way, rsp_cf, rsp_offset and rsp_len are all zero.
- R8: A fill writes tag and states of entry (fill_way, fill_set), replacing the previous contents at the clock edge. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 48 | Byte address of the requested block |
| fill_en | input | 1 | Entry write strobe |
| fill_way | input | 4 | Way of the entry to write |
| fill_set | input | SET_W (4) | Set of the entry to write |
| fill_tag | input | 39 | Super-block address A[47:9] to store |
| fill_state | input | 8 | Per-position valid states to store |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Block found |
| rsp_way | output | 4 | Hitting way |
| rsp_cf | output | 2 | Compression class inferred from the hitting way |
| rsp_offset | output | 6 | Byte offset of the block in the data entry |
| rsp_len | output | 7 | Compressed length in bytes |

## Verification
A wrong set-index hash or a wrong class inference for one way shows up in the first response after a fill aimed at that way. rsp_hit then stays low where a hit is due, or rsp_way or rsp_cf disagree with the group arithmetic. A slip in the state-bit selection or the tag compare shows up as a false hit or a false miss in the same response. Offset and length errors appear as soon as neighbouring blocks packed into one entry are read back. Each of these shows at the ports one cycle after the request that exposes it.

// File: rtl/sktl_pkg.sv
package sktl_pkg;

  localparam int ADDR_W  = 48;
  localparam int TAG_LO  = 9;
  localparam int TAG_W   = ADDR_W - TAG_LO;
  localparam int HI_W    = ADDR_W - 11;
  localparam int SRC_W   = HI_W + 3;
  localparam int NPOS    = 8;
  localparam int NGROUPS = 4;

  typedef logic [1:0] cf_t;

  // Class a way assumes: its group XORed with A[10:9].
  function automatic cf_t group_cf(input logic [1:0] a10a9, input logic [1:0] grp);
    return a10a9 ^ grp;
  endfunction

  // Index source: A[47:11] followed by the block-ID bits the class keeps.
  function automatic logic [SRC_W-1:0] index_src(input logic [ADDR_W-1:6] a, input cf_t cf);
    logic [SRC_W-1:0] s;
    unique case (cf)
      2'd0:    s = {a[47:11], a[8:6]};
      2'd1:    s = {1'b0, a[47:11], a[8:7]};
      2'd2:    s = {2'b0, a[47:11], a[8]};
      default: s = {3'b0, a[47:11]};
    endcase
    return s;
  endfunction

  function automatic logic [5:0] byte_offset(input logic [2:0] blk, input cf_t cf);
    logic [5:0] o;
    unique case (cf)
      2'd0:    o = 6'd0;
      2'd1:    o = {blk[0], 5'b0};
      2'd2:    o = {blk[1:0], 4'b0};
      default: o = {blk[2:0], 3'b0};
    endcase
    return o;
  endfunction

  function automatic logic [6:0] block_len(input cf_t cf);
    return 7'd64 >> cf;
  endfunction

endpackage

// File: rtl/sktl_bank.sv
module sktl_bank
  import sktl_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int WAY_W = 4,
  parameter int WAY   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [NPOS-1:0]  fill_state,
  input  logic [SET_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [NPOS-1:0]  rd_state
);

  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_q [SETS];
  logic [NPOS-1:0]  st_q  [SETS];
  logic             wr_here;

  assign wr_here = fill_en && (fill_way == WAY_W'(WAY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        st_q[s]  <= '0;
      end
    end else if (wr_here) begin
      tag_q[fill_set] <= fill_tag;
      st_q[fill_set]  <= fill_state;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_state = st_q[rd_idx];

  assert_fill_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_here |=> (st_q[$past(fill_set)] == $past(fill_state)) &&
                (tag_q[$past(fill_set)] == $past(fill_tag)));

endmodule

// File: rtl/sktl_probe.sv
module sktl_probe
  import sktl_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int GROUP = 0,
  parameter int SLOT  = 0
) (
  input  logic [ADDR_W-1:6] addr,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [NPOS-1:0]   ent_state,
  output logic [SET_W-1:0]  set_idx,
  output cf_t               cf,
  output logic              hit
);

  localparam int NCHUNK = (SRC_W + SET_W - 1) / SET_W;
  localparam int PAD_W  = NCHUNK * SET_W;
  localparam int ROT    = SLOT % SET_W;

  function automatic logic [SET_W-1:0] fold(input logic [PAD_W-1:0] v);
    logic [SET_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NCHUNK; i++) acc ^= v[i*SET_W +: SET_W];
    return acc;
  endfunction

  function automatic logic [SET_W-1:0] rotl(input logic [SET_W-1:0] x);
    logic [2*SET_W-1:0] d;
    d = {x, x} << ROT;
    return d[2*SET_W-1 -: SET_W];
  endfunction

  logic [SRC_W-1:0] src;
  logic [SET_W-1:0] folded;
  logic             tag_eq;
  logic             pos_ok;

  assign cf      = group_cf(addr[10:9], 2'(GROUP));
  assign src     = index_src(addr, cf);
  assign folded  = fold(PAD_W'(src));
  assign set_idx = rotl(folded) ^ SET_W'(GROUP);
  assign tag_eq  = (ent_tag == addr[ADDR_W-1:TAG_LO]);
  assign pos_ok  = ent_state[addr[8:6]];
  assign hit     = tag_eq && pos_ok;

endmodule

// File: rtl/sktl_merge.sv
module sktl_merge
  import sktl_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int WAY_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          blk,
  input  logic [WAYS-1:0]     hit_vec,
  input  cf_t [WAYS-1:0]      cf_vec,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [WAY_W-1:0]    rsp_way,
  output cf_t                 rsp_cf,
  output logic [5:0]          rsp_offset,
  output logic [6:0]          rsp_len
);

  logic             any_hit;
  logic [WAY_W-1:0] enc;
  cf_t              sel_cf;

  always_comb begin
    any_hit = 1'b0;
    enc     = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i] && !any_hit) begin
        any_hit = 1'b1;
        enc     = WAY_W'(i);
      end
    end
    sel_cf = cf_vec[enc];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_cf     <= '0;
      rsp_offset <= '0;
      rsp_len    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid && any_hit) begin
        rsp_hit    <= 1'b1;
        rsp_way    <= enc;
        rsp_cf     <= sel_cf;
        rsp_offset <= byte_offset(blk, sel_cf);
        rsp_len    <= block_len(sel_cf);
      end else begin
        rsp_hit    <= 1'b0;
        rsp_way    <= '0;
        rsp_cf     <= '0;
        rsp_offset <= '0;
        rsp_len    <= '0;
      end
    end
  end

  assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(hit_vec));

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_len == 7'd0) && (rsp_offset == 6'd0) && (rsp_way == '0) && (rsp_cf == '0));

  assert_offset_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (({1'b0, rsp_offset} & (rsp_len - 7'd1)) == 7'd0));

endmodule

// File: rtl/sktl_lookup.sv
module sktl_lookup
  import sktl_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int WPG   = 4,
  localparam int WAYS  = NGROUPS * WPG,
  localparam int WAY_W = 2 + $clog2(WPG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [47:0]      req_addr,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0] fill_set,
  input  logic [38:0]      fill_tag,
  input  logic [7:0]       fill_state,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic [1:0]       rsp_cf,
  output logic [5:0]       rsp_offset,
  output logic [6:0]       rsp_len
);

  logic [WAYS-1:0]             hit_vec;
  cf_t  [WAYS-1:0]             cf_vec;
  logic [WAYS-1:0][SET_W-1:0]  idx_vec;
  logic [WAYS-1:0][TAG_W-1:0]  tag_vec;
  logic [WAYS-1:0][NPOS-1:0]   st_vec;
  logic                        unused_low_bits;

  assign unused_low_bits = ^req_addr[5:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sktl_bank #(.SET_W(SET_W), .WAY_W(WAY_W), .WAY(w)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_en    (fill_en),
      .fill_way   (fill_way),
      .fill_set   (fill_set),
      .fill_tag   (fill_tag),
      .fill_state (fill_state),
      .rd_idx     (idx_vec[w]),
      .rd_tag     (tag_vec[w]),
      .rd_state   (st_vec[w])
    );

    sktl_probe #(.SET_W(SET_W), .GROUP(w / WPG), .SLOT(w % WPG)) u_probe (
      .addr      (req_addr[47:6]),
      .ent_tag   (tag_vec[w]),
      .ent_state (st_vec[w]),
      .set_idx   (idx_vec[w]),
      .cf        (cf_vec[w]),
      .hit       (hit_vec[w])
    );
  end

  sktl_merge #(.WAYS(WAYS), .WAY_W(WAY_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .blk        (req_addr[8:6]),
    .hit_vec    (hit_vec),
    .cf_vec     (cf_vec),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_cf     (rsp_cf),
    .rsp_offset (rsp_offset),
    .rsp_len    (rsp_len)
  );

  assert_group_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_way[WAY_W-1 -: 2] == (rsp_cf ^ $past(req_addr[10:9]))));

endmodule

// File: tb/sktl_lookup_tb.sv
module sktl_lookup_tb;

  localparam int SET_W = 4;
  localparam int WPG   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_addr = '0;
  logic        fill_en = 1'b0;
  logic [3:0]  fill_way = '0;
  logic [3:0]  fill_set = '0;
  logic [38:0] fill_tag = '0;
  logic [7:0]  fill_state = '0;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_way;
  logic [1:0]  rsp_cf;
  logic [5:0]  rsp_offset;
  logic [6:0]  rsp_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] rng = 64'h1234_5678_9abc_def1;

  sktl_lookup #(.SET_W(SET_W), .WPG(WPG)) u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_idx(input logic [47:0] a, input int cf, input int w);
    logic [63:0] src;
    logic [3:0]  f, r;
    int g, k;
    g = w / WPG;
    k = w % WPG;
    src = 64'(a[47:11]);
    for (int i = 0; i < 3 - cf; i++) src = (src << 1) | 64'(a[8 - i]);
    f = '0;
    for (int b = 0; b < 64; b++) if (src[b]) f[b % SET_W] = ~f[b % SET_W];
    for (int j = 0; j < SET_W; j++) r[(j + k) % SET_W] = f[j];
    return r ^ 4'(g);
  endfunction

  function automatic logic [5:0] ref_off(input logic [47:0] a, input int cf);
    int n;
    n = cf == 0 ? 0 : int'(a[8:6]) % (1 << cf);
    return 6'(n * (64 >> cf));
  endfunction

  task automatic next_addr(output logic [47:0] a);
    rng = rng * 64'd6364136223846793005 + 64'd1442695040888963407;
    a = rng[63:16];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fill(input int w, input logic [3:0] s, input logic [38:0] t, input logic [7:0] st);
    fill_en = 1'b1; fill_way = 4'(w); fill_set = s; fill_tag = t; fill_state = st;
    @(posedge clk);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic lookup(input logic [47:0] a);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid after request", 64'(rsp_valid), 64'd1);
  endtask

  task automatic expect_miss(input string req);
    chk(req, {rsp_hit, rsp_way, rsp_cf, rsp_offset, rsp_len}, 64'd0);
  endtask

  initial begin
    logic [47:0] a, b;
    int g, w;
    logic [3:0] s;
    logic [7:0] bit1;

    do_reset();
    chk("R1 rsp_valid idle after reset", 64'(rsp_valid), 64'd0);
    for (int i = 0; i < 4; i++) begin
      next_addr(a);
      lookup(a);
      expect_miss("R1 lookup after reset misses");
    end
    @(posedge clk); @(negedge clk);
    chk("R2 rsp_valid low without request", 64'(rsp_valid), 64'd0);

    for (int cf = 0; cf < 4; cf++) begin
      for (int k = 0; k < WPG; k++) begin
        for (int n = 0; n < 4; n++) begin
          next_addr(a);
          g = int'(a[10:9]) ^ cf;
          w = g * WPG + k;
          s = ref_idx(a, cf, w);
          bit1 = 8'd1 << a[8:6];
          do_reset();
          fill(w, s, a[47:9], bit1);
          lookup(a);
          chk("R4 R5 R6 hit at hashed set", 64'(rsp_hit), 64'd1);
          chk("R3 hit way", 64'(rsp_way), 64'(w));
          chk("R3 inferred class", 64'(rsp_cf), 64'(cf));
          chk("R7 offset", 64'(rsp_offset), 64'(ref_off(a, cf)));
          chk("R7 length", 64'(rsp_len), 64'(64 >> cf));
          b = a ^ (48'h1 << (6 + n % 3));
          lookup(b);
          expect_miss("R5 neighbour without state misses");
          fill(w, s, a[47:9], ~bit1);
          lookup(a);
          expect_miss("R5 other states do not hit");
          fill(w, s, a[47:9] ^ 39'(1 << (n * 7)), 8'hFF);
          lookup(a);
          expect_miss("R6 tag mismatch misses");
          fill(w, s, a[47:9], 8'h00);
          fill(w, s ^ 4'(1 << n), a[47:9], 8'hFF);
          lookup(a);
          expect_miss("R4 wrong set misses");
        end
      end
    end

    do_reset();
    next_addr(a);
    w = (int'(a[10:9]) ^ 3) * WPG + 2;
    s = ref_idx(a, 3, w);
    fill(w, s, a[47:9], 8'hFF);
    for (int p = 0; p < 8; p++) begin
      b = {a[47:9], 3'(p), a[5:0]};
      lookup(b);
      chk("R7 packed block hit", 64'(rsp_hit), 64'd1);
      chk("R7 packed block offset", 64'(rsp_offset), 64'(p * 8));
      chk("R7 packed block length", 64'(rsp_len), 64'd8);
    end

    do_reset();
    next_addr(a);
    w = (int'(a[10:9]) ^ 1) * WPG + 1;
    s = ref_idx(a, 1, w);
    fill(w, s, a[47:9], 8'd1 << a[8:6]);
    req_valid = 1'b1; req_addr = a;
    fill_en = 1'b1; fill_way = 4'(w); fill_set = s; fill_tag = a[47:9]; fill_state = 8'h00;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
    chk("R8 same-cycle lookup sees old entry", 64'(rsp_hit), 64'd1);
    lookup(a);
    expect_miss("R8 fill replaced states");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule